// File: doc/BRIEF.md
# Tuning Window Centre Selector

This block runs after a sampling-phase sweep of a high-speed card interface. The sweep leaves one pass/fail flag per probe. It covers two full turns of the N-position tap ring, so the flag vector holds 2N bits, and bit i belongs to tap i mod N. On a start strobe the block walks that vector one bit per clock. It tracks the longest stretch of consecutive passing probes and reports the tap at the middle of that stretch, folded back into the range 0..N-1.

The doubled vector lets a passing window that crosses from the last tap back to tap 0 appear as one unbroken run. A best run shorter than three probes is not trusted. In that case the block raises an error instead of naming a tap. On success it raises an arm flag, which tells the surrounding controller to program the chosen tap and turn on automatic re-tuning.

Top module: `tune_window_sel`

## Requirements
- R1: On an accepted start the block captures `result` and `tap_count`. It then examines bits 0 up to 2N-1 of `result` in ascending order, where bit value 1 means pass and 0 means fail. Bits at index 2N and above have no effect. A `tap_count` above MAX_TAPS (default 8) is treated as MAX_TAPS.
- R2: `run_len` reports the length of the longest run of consecutive 1 bits among the examined bits. This includes a run that is still open at the last examined bit.
- R3: When two runs have equal length, the one at the lower index is chosen. A later run replaces the chosen one only if it is strictly longer.
- R4: With the chosen run spanning indices `first` to `last`, `tap` equals ((first + last) / 2) mod N, using integer division.
- R5: If `run_len` is below 3, `error` is 1, `tap` is 0 and `retune_arm` is 0. `run_len` still shows the length that was found. A `tap_count` of 0 always ends this way.
- R6: If `run_len` is 3 or more, `error` is 0 and `retune_arm` is 1.
- R7: `done` is a single-cycle pulse. It goes high 2N+1 clock edges after the edge that accepted start. `tap`, `error`, `run_len` and `retune_arm` become valid together with `done` and hold until the next accepted start, which clears all four to 0.
- R8: A start pulse that arrives while a scan is running is ignored. The running scan keeps its captured vector and N, its result and its timing.
- R9: After reset, `done`, `tap`, `error`, `run_len` and `retune_arm` are all 0.
- R10: A passing window that wraps from tap N-1 to tap 0 is found as one run, and its centre is folded into 0..N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan; accepted only when idle |
| result | input | 2*MAX_TAPS | Probe flags, bit i is probe i, 1 = pass |
| tap_count | input | clog2(MAX_TAPS+1) | Number of taps N in the ring |
| done | output | 1 | One-cycle pulse at the end of a scan |
| tap | output | clog2(MAX_TAPS) | Selected tap, 0 on error |
| error | output | 1 | Best run shorter than three probes |
| run_len | output | clog2(2*MAX_TAPS+1) | Length of the best run |
| retune_arm | output | 1 | Selection succeeded; program tap and enable re-tuning |

## Verification
The vectors include an all-pass sweep, an all-fail sweep, a single window in the middle, and a window that only wraps around the ring. These separate plain centring from the modulo fold. Two equal-length runs show whether the earliest one is kept. A short early run followed by a longer late run shows whether replacement needs a strictly longer run. A run that stays open at the last bit shows whether the close-out at the end is done. Run lengths of exactly two and exactly three sit on either side of the rejection threshold. Cases with small N, N of zero, N above the maximum, and set bits beyond 2N check that the scan length follows N alone. The timing of `done` is checked in every case.

// File: rtl/tws_pkg.sv
package tws_pkg;

    // Shortest passing window that is trusted.
    localparam int unsigned TWS_MIN_RUN = 3;

    typedef enum logic {
        TWS_IDLE = 1'b0,
        TWS_SCAN = 1'b1
    } tws_state_e;

    // Midpoint of a window on the doubled ring, folded into 0..taps-1.
    // The midpoint is below 2*taps, so one subtraction is enough.
    function automatic int unsigned tws_center(input int unsigned first,
                                               input int unsigned last,
                                               input int unsigned taps);
        int unsigned mid;
        mid = (first + last) / 2;
        if (taps == 0) return 0;
        if (mid >= taps) return mid - taps;
        return mid;
    endfunction

endpackage

// File: rtl/tws_ctrl.sv
module tws_ctrl
    import tws_pkg::*;
#(
    parameter int unsigned MAX_TAPS = 8,
    parameter int unsigned NCNT_W   = $clog2(MAX_TAPS + 1),
    parameter int unsigned IDX_W    = $clog2(2 * MAX_TAPS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [NCNT_W-1:0] tap_count,
    output logic              accept,
    output logic              step,
    output logic              finish,
    output logic [IDX_W-1:0]  idx,
    output logic [NCNT_W-1:0] taps_q
);

    tws_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [IDX_W-1:0]  limit_q;
    logic [NCNT_W-1:0] n_eff;

    always_comb begin
        if (tap_count > NCNT_W'(MAX_TAPS)) n_eff = NCNT_W'(MAX_TAPS);
        else                               n_eff = tap_count;
    end

    assign accept = (state_q == TWS_IDLE) && start;
    assign step   = (state_q == TWS_SCAN) && (idx_q != limit_q);
    assign finish = (state_q == TWS_SCAN) && (idx_q == limit_q);
    assign idx    = idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= TWS_IDLE;
            idx_q   <= '0;
            limit_q <= '0;
            taps_q  <= '0;
        end else if (accept) begin
            state_q <= TWS_SCAN;
            idx_q   <= '0;
            limit_q <= IDX_W'({n_eff, 1'b0});
            taps_q  <= n_eff;
        end else if (step) begin
            idx_q <= idx_q + 1'b1;
        end else if (finish) begin
            state_q <= TWS_IDLE;
        end
    end

    // R1: the scan index never passes the 2N limit
    p_idx_bound_r1: assert property (@(posedge clk) disable iff (rst)
        (state_q == TWS_SCAN) |-> (idx_q <= limit_q));

    // R8: a scan in progress keeps its bounds whatever start does
    p_start_ignored_r8: assert property (@(posedge clk) disable iff (rst)
        ((state_q == TWS_SCAN) && !finish) |=>
            ((state_q == TWS_SCAN) && $stable(limit_q) && $stable(taps_q)));

    // R7: the end of a scan returns to idle
    p_finish_idle_r7: assert property (@(posedge clk) disable iff (rst)
        finish |=> (state_q == TWS_IDLE));

endmodule

// File: rtl/tws_run_track.sv
module tws_run_track
    import tws_pkg::*;
#(
    parameter int unsigned IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    input  logic             pass_bit,
    input  logic [IDX_W-1:0] idx,
    output logic [IDX_W-1:0] fin_len,
    output logic [IDX_W-1:0] fin_first,
    output logic [IDX_W-1:0] fin_last
);

    logic [IDX_W-1:0] run_q;
    logic [IDX_W-1:0] best_len_q;
    logic [IDX_W-1:0] best_first_q;
    logic [IDX_W-1:0] best_last_q;
    logic             run_wins;

    // Strictly longer only: an equal later run never displaces the earlier one.
    assign run_wins = run_q > best_len_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            run_q        <= '0;
            best_len_q   <= '0;
            best_first_q <= '0;
            best_last_q  <= '0;
        end else if (step) begin
            if (pass_bit) begin
                run_q <= run_q + 1'b1;
            end else begin
                run_q <= '0;
                if (run_wins) begin
                    best_len_q   <= run_q;
                    best_first_q <= idx - run_q;
                    best_last_q  <= idx - 1'b1;
                end
            end
        end
    end

    // Close-out of a run still open at the end of the vector (idx == 2N here).
    always_comb begin
        if (run_wins) begin
            fin_len   = run_q;
            fin_first = idx - run_q;
            fin_last  = idx - 1'b1;
        end else begin
            fin_len   = best_len_q;
            fin_first = best_first_q;
            fin_last  = best_last_q;
        end
    end

    // R2: a run cannot be longer than the bits seen so far
    p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run_q <= idx);

    // R3: the best length never shrinks during a scan
    p_best_mono_r3: assert property (@(posedge clk) disable iff (rst)
        (step && !clear) |=> (best_len_q >= $past(best_len_q)));

    // R4: the stored span agrees with the stored length
    p_best_span_r4: assert property (@(posedge clk) disable iff (rst)
        (best_len_q != '0) |-> ((best_last_q - best_first_q + 1'b1) == best_len_q));

endmodule

// File: rtl/tws_pick.sv
module tws_pick
    import tws_pkg::*;
#(
    parameter int unsigned IDX_W  = 5,
    parameter int unsigned NCNT_W = 4,
    parameter int unsigned TAP_W  = 3
) (
    input  logic [IDX_W-1:0]  fin_len,
    input  logic [IDX_W-1:0]  fin_first,
    input  logic [IDX_W-1:0]  fin_last,
    input  logic [NCNT_W-1:0] taps,
    output logic              ok,
    output logic [TAP_W-1:0]  tap
);

    int unsigned centre;

    always_comb begin
        ok     = fin_len >= IDX_W'(TWS_MIN_RUN);
        centre = tws_center(int'(fin_first), int'(fin_last), int'(taps));
        tap    = ok ? TAP_W'(centre) : '0;
    end

endmodule

// File: rtl/tune_window_sel.sv
module tune_window_sel
    import tws_pkg::*;
#(
    parameter int unsigned MAX_TAPS = 8,
    localparam int unsigned BITS    = 2 * MAX_TAPS,
    localparam int unsigned NCNT_W  = $clog2(MAX_TAPS + 1),
    localparam int unsigned IDX_W   = $clog2(BITS + 1),
    localparam int unsigned TAP_W   = (MAX_TAPS > 1) ? $clog2(MAX_TAPS) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [BITS-1:0]   result,
    input  logic [NCNT_W-1:0] tap_count,
    output logic              done,
    output logic [TAP_W-1:0]  tap,
    output logic              error,
    output logic [IDX_W-1:0]  run_len,
    output logic              retune_arm
);

    logic              accept, step, finish;
    logic [IDX_W-1:0]  idx;
    logic [NCNT_W-1:0] taps_q;
    logic [BITS-1:0]   bitmap_q;
    logic [BITS-1:0]   shifted;
    logic              pass_bit;
    logic [IDX_W-1:0]  fin_len, fin_first, fin_last;
    logic              pick_ok;
    logic [TAP_W-1:0]  pick_tap;

    tws_ctrl #(.MAX_TAPS(MAX_TAPS), .NCNT_W(NCNT_W), .IDX_W(IDX_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .tap_count(tap_count),
        .accept(accept), .step(step), .finish(finish),
        .idx(idx), .taps_q(taps_q)
    );

    always_ff @(posedge clk) begin
        if (rst)         bitmap_q <= '0;
        else if (accept) bitmap_q <= result;
    end

    assign shifted  = bitmap_q >> idx;
    assign pass_bit = shifted[0];

    tws_run_track #(.IDX_W(IDX_W)) u_track (
        .clk(clk), .rst(rst), .clear(accept), .step(step),
        .pass_bit(pass_bit), .idx(idx),
        .fin_len(fin_len), .fin_first(fin_first), .fin_last(fin_last)
    );

    tws_pick #(.IDX_W(IDX_W), .NCNT_W(NCNT_W), .TAP_W(TAP_W)) u_pick (
        .fin_len(fin_len), .fin_first(fin_first), .fin_last(fin_last),
        .taps(taps_q), .ok(pick_ok), .tap(pick_tap)
    );

    always_ff @(posedge clk) begin
        if (rst || accept) begin
            done       <= 1'b0;
            tap        <= '0;
            error      <= 1'b0;
            run_len    <= '0;
            retune_arm <= 1'b0;
        end else if (finish) begin
            done       <= 1'b1;
            tap        <= pick_tap;
            error      <= !pick_ok;
            run_len    <= fin_len;
            retune_arm <= pick_ok;
        end else begin
            done <= 1'b0;
        end
    end

    // R7: done lasts exactly one cycle
    p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R7: results hold between scans
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (!accept && !finish) |=>
            ($stable(tap) && $stable(error) && $stable(run_len) && $stable(retune_arm)));

    // R5: a rejected window names no tap and does not arm re-tuning
    p_err_no_tap_r5: assert property (@(posedge clk) disable iff (rst)
        error |-> ((tap == '0) && !retune_arm));

    // R6: arming needs a window of at least three probes
    p_arm_len_r6: assert property (@(posedge clk) disable iff (rst)
        retune_arm |-> ((run_len >= IDX_W'(TWS_MIN_RUN)) && !error));

    // R4: a selected tap lies on the ring
    p_tap_range_r4: assert property (@(posedge clk) disable iff (rst)
        (done && !error) |-> (TAP_W'(tap) < taps_q));

endmodule

// File: tb/tb_tune_window_sel.sv
`timescale 1ns/1ps
module tb_tune_window_sel;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [15:0] result;
    logic [3:0]  tap_count;
    logic        done;
    logic [2:0]  tap;
    logic        error;
    logic [4:0]  run_len;
    logic        retune_arm;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    tune_window_sel #(.MAX_TAPS(8)) dut (
        .clk(clk), .rst(rst), .start(start), .result(result),
        .tap_count(tap_count), .done(done), .tap(tap), .error(error),
        .run_len(run_len), .retune_arm(retune_arm)
    );

    always #5 clk = ~clk;

    // Expected values worked out by hand from the requirements.
    localparam int NV = 14;
    localparam logic [15:0] V_MAP [NV] = '{
        16'hFFFF, 16'h0000, 16'h007C, 16'h00BB, 16'h00E7, 16'h0003, 16'hFC03,
        16'hFFCF, 16'h03E0, 16'h0003, 16'h000F, 16'h0F07, 16'hFFFF, 16'hFFFF};
    localparam int V_N   [NV] = '{8, 8, 8, 4, 8, 8, 8, 3, 5, 1, 2, 8, 12, 0};
    localparam int V_TAP [NV] = '{7, 0, 4, 0, 1, 0, 4, 1, 2, 0, 1, 1, 7, 0};
    localparam int V_ERR [NV] = '{0, 1, 0, 0, 0, 1, 0, 0, 0, 1, 0, 0, 0, 1};
    localparam int V_LEN [NV] = '{16, 0, 5, 3, 3, 2, 6, 4, 5, 2, 4, 4, 16, 0};
    // Case tags: 0 R2 all pass, 1 R5 all fail, 2 R4 mid window, 3 R10 wrap,
    // 4 R3 tie keeps earliest, 5 R5 length two, 6 R2 open run at end,
    // 7 R1 high bits ignored, 8 R4 fold, 9 R5 N=1, 10 R4 N=2,
    // 11 R3 strictly longer later, 12 R1 N clamp, 13 R5 N zero.
    localparam string V_TAG [NV] = '{"R2", "R5", "R4", "R10", "R3", "R5", "R2",
                                     "R1", "R4", "R5", "R4", "R3", "R1", "R5"};

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic launch(input logic [15:0] map, input int n);
        @(negedge clk);
        result    = map;
        tap_count = n[3:0];
        start     = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 0;
        do begin
            @(posedge clk);
            #1 cyc++;
        end while (!done && cyc < 200);
    endtask

    task automatic check_result(input string tag, input int n, input int cyc,
                                input int etap, input int eerr, input int elen);
        int neff;
        neff = (n > 8) ? 8 : n;
        chk(cyc == 2 * neff + 1, "R7", "done latency", cyc, 2 * neff + 1);
        chk(tap == etap[2:0], tag, "tap", int'(tap), etap);
        chk(error == eerr[0], tag, "error", int'(error), eerr);
        chk(run_len == elen[4:0], "R2", "run_len", int'(run_len), elen);
        chk(retune_arm == !eerr[0], "R6", "retune_arm", int'(retune_arm), 1 - eerr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int cyc;
        logic [2:0] t0;
        rst = 1'b1; start = 1'b0; result = '0; tap_count = '0;
        repeat (3) @(posedge clk);
        #1;
        chk(done == 0 && tap == 0 && error == 0 && run_len == 0 && retune_arm == 0,
            "R9", "reset outputs", int'({done, tap, error, run_len, retune_arm}), 0);
        @(negedge clk); rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) begin
            launch(V_MAP[i], V_N[i]);
            wait_done(cyc);
            check_result(V_TAG[i], V_N[i], cyc, V_TAP[i], V_ERR[i], V_LEN[i]);
            t0 = tap;
            repeat (3) @(posedge clk);
            #1;
            chk(!done, "R7", "done single cycle", int'(done), 0);
            chk(tap == t0 && error == V_ERR[i][0], "R7", "hold tap", int'(tap), int'(t0));
        end

        // R7: a new start clears the held results
        launch(16'hFFFF, 8);
        wait_done(cyc);
        launch(16'h0000, 8);
        chk(tap == 0 && error == 0 && run_len == 0 && retune_arm == 0 && done == 0,
            "R7", "clear on start", int'({tap, error, run_len, retune_arm}), 0);
        wait_done(cyc);
        check_result("R5", 8, cyc, 0, 1, 0);

        // R8: start during a scan is ignored
        launch(16'hFFFF, 8);
        cyc = 0;
        repeat (4) begin
            @(posedge clk);
            #1 cyc++;
        end
        @(negedge clk);
        result = 16'h0000; tap_count = 4'd2; start = 1'b1;
        @(posedge clk);
        #1 begin start = 1'b0; cyc++; end
        while (!done && cyc < 200) begin
            @(posedge clk);
            #1 cyc++;
        end
        chk(cyc == 17, "R8", "latency with stray start", cyc, 17);
        chk(tap == 3'd7 && run_len == 5'd16 && !error, "R8", "result with stray start",
            int'(tap), 7);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule